// File: doc/BRIEF.md
# Key-Protected Watchdog and Interval Timer

This block is an 8-bit up-counter that serves as a system watchdog or as a periodic interval timer. Its two software-visible registers are a counter and a control/status register. Software can change either one only through a single 16-bit store whose upper byte holds that register's own key value. The lower byte of the store is the data written. This guards against stray byte or word stores from runaway code.

A free-running prescaler divides the peripheral clock. A 3-bit select field chooses which tap advances the counter. When the counter wraps from 0xFF to 0x00 with the timer enabled, it does one of two things, depending on a mode bit. In watchdog mode it sets a flag and issues a one-cycle reset request, which carries a reset-type bit. In interval mode it sets a flag that drives a level interrupt.

The counter also times oscillator settling after standby. Software clears the enable bit and preloads the counter before standby. A wake event then runs the counter from the preload value. At the wrap, the block emits a clock-release pulse instead of a reset or an interrupt.

Top module: `keyed_wdog`

## Requirements
- R1: A write changes a register only when `bus_be` equals 4'b0011, which marks a 16-bit transfer. Any other byte-enable pattern, including 4'b0001 (byte) and 4'b1111 (32-bit), leaves both registers unchanged.
- R2: A 16-bit write at offset 0x84 loads `bus_wdata[7:0]` into the counter only when `bus_wdata[15:8]` is 0x5A. Any other upper byte, including 0xA5, is ignored.
- R3: A 16-bit write at offset 0x86 loads `bus_wdata[7:0]` into the control/status register only when `bus_wdata[15:8]` is 0xA5. Any other upper byte is ignored.
- R4: `bus_rdata` returns {0x00, counter} at 0x84 and {0x00, control/status} at 0x86, with no key needed. Any other offset reads 0x0000.
- R5: Control/status bit 7 enables counting. While it is 0 and no settling is in progress, the counter holds its value.
- R6: Control/status bits 2:0 select the count rate. Codes 0 to 7 select one increment per 1, 4, 16, 32, 64, 256, 1024 and 4096 clock cycles, respectively.
- R7: When bit 6 is 0 (interval mode), a wrap from 0xFF sets bit 3. The counter becomes 0x00, `wdt_irq` follows bit 3 as a level, and no reset request is issued.
- R8: When bit 6 is 1 (watchdog mode), a wrap from 0xFF sets bit 4 and pulses `wdt_rst_req` for exactly one cycle. `wdt_rst_kind` reflects bit 5.
- R9: A keyed write of the control/status register replaces all eight bits. Writing 0 clears both overflow flags and drops `wdt_irq`.
- R10: A `wake` pulse while `standby` is high starts settling. The counter advances from its preload value at the selected rate, even with bit 7 at 0. The wrap gives a single-cycle `clk_release` pulse, leaves the flags and `wdt_rst_req` untouched, and ends settling. A `wake` pulse without `standby` has no effect.
- R11: After reset, the counter and control/status register are 0x00, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_be | input | 4 | Byte enables; 4'b0011 marks a 16-bit transfer |
| bus_wdata | input | 16 | Write halfword: key in [15:8], data in [7:0] |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data |
| standby | input | 1 | High while the chip is in standby |
| wake | input | 1 | Wake event pulse |
| wdt_irq | output | 1 | Interval interrupt level |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| wdt_rst_kind | output | 1 | Reset type that goes with the request |
| clk_release | output | 1 | One-cycle pulse ending oscillator settling |

## Verification
The bench attacks key checking from every side: byte and 32-bit stores with the right key, each register's key sent to the other register, and an off-by-one key. A design that decodes the key loosely, or that ignores the transfer size, would show a changed readback. Wrap timing is counted edge by edge, in both interval and watchdog mode, and at several prescaler ratios. An off-by-one in the wrap detection or in a divide tap would shift the flag, the count or the reset pulse by a cycle. The standby path is checked for counting with the enable bit at 0 and for a single release pulse that sets no flag. A design that reused the watchdog path would instead raise a flag or a reset there.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

  localparam int CNT_W = 8;

  typedef struct packed {
    logic       tme;    // count enable
    logic       wdog;   // 1: watchdog, 0: interval
    logic       rkind;  // reset type
    logic       wovf;   // watchdog overflow flag
    logic       iovf;   // interval overflow flag
    logic [2:0] cks;    // rate select
  } csr_t;

  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    div_shift = 0;
      3'd1:    div_shift = 2;
      3'd2:    div_shift = 4;
      3'd3:    div_shift = 5;
      3'd4:    div_shift = 6;
      3'd5:    div_shift = 8;
      3'd6:    div_shift = 10;
      default: div_shift = 12;
    endcase
  endfunction

endpackage

// File: rtl/keyed_wdog_prescale.sv
module keyed_wdog_prescale
  import keyed_wdog_pkg::*;
#(
  parameter int PRE_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cks,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] one_sh, mask;

  always_comb begin
    pre_d  = pre_q + PRE_W'(1);
    one_sh = PRE_W'(1) << div_shift(cks);
    mask   = one_sh - PRE_W'(1);
    tick   = &(pre_q | ~mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/keyed_wdog_decode.sv
module keyed_wdog_decode #(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] CNT_OFS = 8'h84,
  parameter logic [7:0] CSR_OFS = 8'h86,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [15:0]       wdata,
  input  logic              we,
  output logic              cnt_wr,
  output logic              csr_wr,
  output logic [7:0]        wbyte
);

  localparam logic [3:0] HALF_BE = 4'b0011;

  logic half_ok;

  always_comb begin
    half_ok = we && (be == HALF_BE);
    cnt_wr  = half_ok && (addr == ADDR_W'(CNT_OFS)) && (wdata[15:8] == CNT_KEY);
    csr_wr  = half_ok && (addr == ADDR_W'(CSR_OFS)) && (wdata[15:8] == CSR_KEY);
    wbyte   = wdata[7:0];
  end

  // R1: non-halfword transfers never reach a register
  p_size_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (be != HALF_BE) |-> (!cnt_wr && !csr_wr));

  // R2/R3: at most one register is written per transfer
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_wr && csr_wr));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter int         PRE_W   = 12,
  parameter logic [7:0] CNT_OFS = 8'h84,
  parameter logic [7:0] CSR_OFS = 8'h86,
  parameter logic [7:0] CNT_KEY = 8'h5A,
  parameter logic [7:0] CSR_KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_we,
  output logic [15:0]       bus_rdata,
  input  logic              standby,
  input  logic              wake,
  output logic              wdt_irq,
  output logic              wdt_rst_req,
  output logic              wdt_rst_kind,
  output logic              clk_release
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic       tick, cnt_wr, csr_wr;
  logic [7:0] wbyte;

  keyed_wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_s),
    .cks  (csr_q.cks),
    .tick (tick)
  );

  keyed_wdog_decode #(
    .ADDR_W (ADDR_W),
    .CNT_OFS(CNT_OFS),
    .CSR_OFS(CSR_OFS),
    .CNT_KEY(CNT_KEY),
    .CSR_KEY(CSR_KEY)
  ) u_dec (
    .clk   (clk),
    .rst_n (rst_s),
    .addr  (bus_addr),
    .be    (bus_be),
    .wdata (bus_wdata),
    .we    (bus_we),
    .cnt_wr(cnt_wr),
    .csr_wr(csr_wr),
    .wbyte (wbyte)
  );

  logic [CNT_W-1:0] cnt_q, cnt_d;
  csr_t             csr_q, csr_d;
  logic             settle_q, settle_d;
  logic             rreq_q, rreq_d;
  logic             rel_q, rel_d;
  logic             run, step, ovf;

  // next state
  always_comb begin
    run  = csr_q.tme | settle_q;
    step = run & tick;
    ovf  = step & (cnt_q == CNT_MAX);

    cnt_d = cnt_q;
    if (step)   cnt_d = cnt_q + CNT_W'(1);
    if (cnt_wr) cnt_d = wbyte;

    csr_d = csr_q;
    if (ovf && !settle_q) begin
      if (csr_q.wdog) csr_d.wovf = 1'b1;
      else            csr_d.iovf = 1'b1;
    end
    if (csr_wr) csr_d = csr_t'(wbyte);

    rreq_d = ovf & ~settle_q & csr_q.wdog;
    rel_d  = ovf & settle_q;

    settle_d = settle_q;
    if (settle_q) begin
      if (ovf) settle_d = 1'b0;
    end else if (standby && wake) begin
      settle_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q    <= '0;
      csr_q    <= '0;
      settle_q <= 1'b0;
      rreq_q   <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      csr_q    <= csr_d;
      settle_q <= settle_d;
      rreq_q   <= rreq_d;
      rel_q    <= rel_d;
    end
  end

  always_comb begin
    if (bus_addr == ADDR_W'(CNT_OFS))      bus_rdata = {8'h00, cnt_q};
    else if (bus_addr == ADDR_W'(CSR_OFS)) bus_rdata = {8'h00, csr_q};
    else                                   bus_rdata = 16'h0000;
  end

  assign wdt_irq      = csr_q.iovf;
  assign wdt_rst_req  = rreq_q;
  assign wdt_rst_kind = csr_q.rkind;
  assign clk_release  = rel_q;

  // R5: no enable, no settling, no write -> counter holds
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  // R7: interval flag rises only with the counter wrapped to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(csr_q.iovf) && !$past(csr_wr)) |-> (cnt_q == '0 || $past(cnt_wr)));

  // R8: reset request is a single-cycle pulse
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_s)
    wdt_rst_req |=> !wdt_rst_req);

  // R8: reset request comes with the watchdog flag set
  p_rst_flag_r8: assert property (@(posedge clk) disable iff (!rst_s)
    wdt_rst_req |-> (csr_q.wovf || $past(csr_wr)));

  // R10: clock release is a single-cycle pulse with the counter wrapped
  p_release_pulse_r10: assert property (@(posedge clk) disable iff (!rst_s)
    clk_release |=> !clk_release);

  p_release_wrap_r10: assert property (@(posedge clk) disable iff (!rst_s)
    clk_release |-> (cnt_q == '0 || $past(cnt_wr)));

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;

  localparam logic [7:0] A_CNT = 8'h84;
  localparam logic [7:0] A_CSR = 8'h86;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [15:0] bus_wdata;
  logic        bus_we;
  logic [15:0] bus_rdata;
  logic        standby, wake;
  logic        wdt_irq, wdt_rst_req, wdt_rst_kind, clk_release;

  always #2 clk = ~clk;  // 250 MHz

  keyed_wdog u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .standby     (standby),
    .wake        (wake),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req),
    .wdt_rst_kind(wdt_rst_kind),
    .clk_release (clk_release)
  );

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  logic     rd_pend = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares at the falling edge
  always @(negedge clk) begin
    if (rd_pend) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  // driver: called between edges; takes effect at the next rising edge
  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [15:0] d);
    bus_addr  = a;
    bus_be    = be;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk); #1;
    bus_we    = 1'b0;
  endtask

  // driver: read without consuming a rising edge
  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    sb_item_t it;
    bus_addr = a;
    it.exp   = exp;
    it.tag   = tag;
    sb_q.push_back(it);
    rd_pend  = 1'b1;
    @(negedge clk); #1;
    rd_pend  = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 8'h00; bus_be = 4'h0; bus_wdata = 16'h0;
    bus_we = 1'b0; standby = 1'b0; wake = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R11 reset state
    rd(A_CNT, 16'h0000, "R11 counter");
    rd(A_CSR, 16'h0000, "R11 csr");
    chk("R11 outputs", {12'h0, wdt_irq, wdt_rst_req, wdt_rst_kind, clk_release}, 16'h0);

    // R2 keyed counter write, R4 read format
    wr(A_CNT, 4'b0011, 16'h5A12);
    rd(A_CNT, 16'h0012, "R2 keyed counter write");
    rd(8'h80, 16'h0000, "R4 unmapped offset");
    wr(A_CNT, 4'b0011, 16'h5B34);
    rd(A_CNT, 16'h0012, "R2 wrong key");
    wr(A_CNT, 4'b0011, 16'hA534);
    rd(A_CNT, 16'h0012, "R2 csr key on counter");
    // R1 byte and 32-bit transfers ignored
    wr(A_CNT, 4'b0001, 16'h5A34);
    rd(A_CNT, 16'h0012, "R1 byte write");
    wr(A_CNT, 4'b1111, 16'h5A34);
    rd(A_CNT, 16'h0012, "R1 32-bit write");
    wr(A_CSR, 4'b1111, 16'hA507);
    rd(A_CSR, 16'h0000, "R1 32-bit csr write");

    // R3 keyed csr write
    wr(A_CSR, 4'b0011, 16'h5A07);
    rd(A_CSR, 16'h0000, "R3 wrong key");
    wr(A_CSR, 4'b0011, 16'hA507);
    rd(A_CSR, 16'h0007, "R3 keyed csr write");
    rd(A_CNT, 16'h0012, "R5 disabled counter holds");

    // R5 count enable, ratio 1
    wr(A_CSR, 4'b0011, 16'hA500);
    wr(A_CNT, 4'b0011, 16'h5A00);
    wr(A_CSR, 4'b0011, 16'hA580);
    cyc(10);
    rd(A_CNT, 16'h000A, "R5 R6 ten increments at ratio 1");
    wr(A_CSR, 4'b0011, 16'hA500);
    rd(A_CNT, 16'h000B, "R5 last increment at disable edge");
    cyc(5);
    rd(A_CNT, 16'h000B, "R5 holds after disable");

    // R6 ratios 4, 16, 4096
    wr(A_CNT, 4'b0011, 16'h5A00);
    wr(A_CSR, 4'b0011, 16'hA581);
    cyc(40);
    rd(A_CNT, 16'h000A, "R6 ratio 4");
    wr(A_CSR, 4'b0011, 16'hA500);
    wr(A_CNT, 4'b0011, 16'h5A00);
    wr(A_CSR, 4'b0011, 16'hA582);
    cyc(160);
    rd(A_CNT, 16'h000A, "R6 ratio 16");
    wr(A_CSR, 4'b0011, 16'hA500);
    wr(A_CNT, 4'b0011, 16'h5A00);
    wr(A_CSR, 4'b0011, 16'hA587);
    cyc(8192);
    rd(A_CNT, 16'h0002, "R6 ratio 4096");
    wr(A_CSR, 4'b0011, 16'hA500);

    // R7 interval overflow
    wr(A_CNT, 4'b0011, 16'h5AFD);
    wr(A_CSR, 4'b0011, 16'hA580);
    cyc(2);
    chk("R7 no irq before wrap", {15'h0, wdt_irq}, 16'h0);
    cyc(1);
    rd(A_CSR, 16'h0088, "R7 interval flag");
    chk("R7 irq level", {15'h0, wdt_irq}, 16'h1);
    chk("R7 no reset in interval mode", {15'h0, wdt_rst_req}, 16'h0);
    cyc(1);
    rd(A_CNT, 16'h0001, "R7 counter wrapped and continues");
    // R9 clear flags
    wr(A_CSR, 4'b0011, 16'hA500);
    rd(A_CSR, 16'h0000, "R9 flag cleared");
    chk("R9 irq dropped", {15'h0, wdt_irq}, 16'h0);

    // R8 watchdog overflow
    wr(A_CNT, 4'b0011, 16'h5AFE);
    wr(A_CSR, 4'b0011, 16'hA5E0);
    cyc(1);
    chk("R8 no reset before wrap", {15'h0, wdt_rst_req}, 16'h0);
    cyc(1);
    chk("R8 reset request", {15'h0, wdt_rst_req}, 16'h1);
    chk("R8 reset kind", {15'h0, wdt_rst_kind}, 16'h1);
    rd(A_CSR, 16'h00F0, "R8 watchdog flag");
    chk("R8 no irq in watchdog mode", {15'h0, wdt_irq}, 16'h0);
    cyc(1);
    chk("R8 single-cycle pulse", {15'h0, wdt_rst_req}, 16'h0);
    wr(A_CSR, 4'b0011, 16'hA500);
    rd(A_CSR, 16'h0000, "R9 watchdog flag cleared");

    // R10 standby settling
    wr(A_CNT, 4'b0011, 16'h5AFC);
    wake = 1'b1; cyc(1); wake = 1'b0;
    cyc(6);
    rd(A_CNT, 16'h00FC, "R10 wake without standby ignored");
    standby = 1'b1;
    cyc(3);
    rd(A_CNT, 16'h00FC, "R10 standby alone holds");
    wake = 1'b1; cyc(1); wake = 1'b0;
    cyc(3);
    rd(A_CNT, 16'h00FF, "R10 settling counts with enable off");
    chk("R10 no release before wrap", {15'h0, clk_release}, 16'h0);
    cyc(1);
    chk("R10 clock release", {15'h0, clk_release}, 16'h1);
    chk("R10 no reset during settling", {15'h0, wdt_rst_req}, 16'h0);
    rd(A_CSR, 16'h0000, "R10 no flag during settling");
    cyc(1);
    chk("R10 single release pulse", {15'h0, clk_release}, 16'h0);
    cyc(4);
    rd(A_CNT, 16'h0000, "R10 counting stops after release");
    standby = 1'b0;

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule